// File: doc/BRIEF.md
# Movable Sprite Position and Scan Unit

This block draws one movable 8-pixel sprite onto a scanline as a serial pixel stream. A six-bit feedback shift register tracks the horizontal position. It steps once every four motion ticks and has a period of 40 steps, so one full period is 160 ticks. A motion tick is any clock cycle in which the visible-pixel enable or an extra stuffed pulse is high. With no tick, all position and scan state holds its exact phase. Blanking is therefore transparent, and extra pulses move the sprite left by one tick each.

Fixed decodes of the position count start the sprite's copies. The main copy starts on every wrap. A 3-bit mode selects up to two extra copies (close, medium, far) or a 2x/4x stretch. A 3-bit binary scan counter walks the eight graphics bits. It can be mirrored by a reflect bit. The graphics byte comes from a pair of registers: a "current" one that the object's own write updates, and a "held" one that receives the current value whenever the partner object's graphics are written. A select bit picks which of the two feeds the output.

All pins are plain control and data lines that are sampled every clock. The pixel output is produced continuously with no flow control, so back-pressure does not apply.

Top module: `sprite_unit`

## Requirements
- R1: The position count wraps every 40 steps of 4 ticks. The main copy starts on every wrap. Its pixel 0 is on the output once 162 + 160*m ticks (m >= 0) have completed after a position reset or a block reset. The counter never sits in the all-ones state.
- R2: Extra copies start from decodes at step 3 (mode 3'b001 or 3'b011), step 7 (mode 3'b010, 3'b011 or 3'b110) and step 15 (mode 3'b100 or 3'b110). A copy decoded at step d shows pixel 0 once 4*d + 6 + 160*m ticks have completed.
- R3: A position reset clears the count and the tick phase and starts no copy. The first main copy after it therefore appears only after a full period. Block reset leaves the same position state, with no copy active and both graphics registers at zero.
- R4: A tick is motion_en OR stuff_pulse. In a cycle with no tick, the position count, the phase and the scan state all hold.
- R5: A stuffed pulse while motion_en is low advances position and scan exactly as a visible-pixel tick does.
- R6: Once started, the scan counter runs through pixels 0 to 7 and is not cleared by a hold. A copy that is interrupted by a hold resumes where it stopped.
- R7: Mode 3'b101 holds each pixel for 2 ticks and mode 3'b111 holds each for 4 ticks; all other modes hold each pixel for 1 tick. Stretch modes draw only the main copy.
- R8: With reflect low, pixel p shows graphics bit 7-p (pixel 0 is the most significant bit). With reflect high, pixel p shows bit p. A change of reflect takes effect on the output at once.
- R9: gfx_wr loads gfx_data into the current register. partner_wr copies the current register into the held register, and when both strobes arrive together the held register takes the previous current value. delay_sel = 1 selects the held register and 0 selects the current one, with immediate effect.
- R10: pix is low whenever no copy is being drawn, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| motion_en | input | 1 | Visible-pixel motion tick enable |
| stuff_pulse | input | 1 | Extra motion tick, used during blanking |
| pos_reset | input | 1 | Position reset strobe |
| gfx_wr | input | 1 | Write strobe for this object's graphics |
| gfx_data | input | 8 | Graphics byte to write |
| partner_wr | input | 1 | Partner object's graphics write strobe |
| mode | input | 3 | Copy and stretch mode |
| reflect | input | 1 | Mirror the pixel order |
| delay_sel | input | 1 | 1 selects the held graphics register, 0 the current one |
| pix | output | 1 | Serial sprite pixel |

## Verification
Every mode value is run from a position reset through two full periods with a graphics byte whose bits differ from one another. This separates the close, medium and far start points, the main-copy wrap, and the 1x/2x/4x pixel widths by the tick at which each bit appears. A pass with reflect and the graphics select toggling mid-draw, and with current and held writes interleaved, tells the immediate-effect paths apart from the registered ones. A final pass thins motion_en into irregular bursts and adds stuffed pulses in the gaps. It shows that the position and scan state freeze and resume on tick count alone, so a copy split by a hold completes correctly.

// File: rtl/sprite_pkg.sv
package sprite_pkg;

  localparam int POS_W = 6;

  // One step of the position shift register: new top bit is XNOR of the two low bits.
  function automatic logic [POS_W-1:0] pos_step(input logic [POS_W-1:0] s);
    return {~(s[1] ^ s[0]), s[POS_W-1:1]};
  endfunction

  // Register state reached after n steps from zero.
  function automatic logic [POS_W-1:0] pos_state_at(input int n);
    logic [POS_W-1:0] s;
    s = '0;
    for (int i = 0; i < n; i++) s = pos_step(s);
    return s;
  endfunction

  typedef enum logic [1:0] {COPY_CLOSE, COPY_MED, COPY_FAR, COPY_MAIN} copy_e;

  // Whether a copy start is let through for a given mode.
  function automatic logic copy_allowed(input logic [2:0] md, input copy_e c);
    case (c)
      COPY_CLOSE: return (md == 3'b001) || (md == 3'b011);
      COPY_MED:   return (md == 3'b011) || (md == 3'b010) || (md == 3'b110);
      COPY_FAR:   return (md == 3'b100) || (md == 3'b110);
      default:    return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/sprite_pos_counter.sv
module sprite_pos_counter
  import sprite_pkg::*;
#(
  parameter int PERIOD   = 40,
  parameter int CLOSE_AT = 3,
  parameter int MED_AT   = 7,
  parameter int FAR_AT   = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       pos_reset,
  input  logic [2:0] mode,
  output logic [1:0] phase,
  output logic       start
);

  localparam int NCOPY = 4;
  localparam int DEC_AT [NCOPY] = '{CLOSE_AT, MED_AT, FAR_AT, PERIOD - 1};
  localparam logic [POS_W-1:0] WRAP_ST = pos_state_at(PERIOD - 1);

  logic [POS_W-1:0] cnt;
  logic [NCOPY-1:0] hit;
  logic             armed;

  for (genvar c = 0; c < NCOPY; c++) begin : g_dec
    localparam logic [POS_W-1:0] DEC_ST = pos_state_at(DEC_AT[c]);
    assign hit[c] = (cnt == DEC_ST) && copy_allowed(mode, copy_e'(c));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pos_reset) begin
      cnt   <= '0;
      phase <= '0;
      armed <= 1'b0;
      start <= 1'b0;
    end else if (tick) begin
      phase <= phase + 2'd1;
      start <= armed;
      armed <= (phase == 2'd3) && (|hit);
      if (phase == 2'd3) begin
        if (cnt == WRAP_ST || cnt == '1) cnt <= '0;
        else                             cnt <= pos_step(cnt);
      end
    end
  end

  AST_NO_ILLEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '1);  // R1
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pos_reset && phase == 2'd3 && cnt == WRAP_ST) |=> cnt == '0);  // R1
  AST_POS_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pos_reset |=> (cnt == '0 && phase == 2'd0 && !start));  // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !pos_reset) |=> ($stable(cnt) && $stable(phase) && $stable(start)));  // R4

endmodule

// File: rtl/sprite_scan.sv
module sprite_scan #(
  parameter int PIXELS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      start,
  input  logic [2:0]                mode,
  input  logic [1:0]                phase,
  output logic [$clog2(PIXELS)-1:0] scan,
  output logic                      active
);

  localparam int SW = $clog2(PIXELS);
  localparam logic [SW-1:0] LAST = SW'(PIXELS - 1);

  logic adv;

  always_comb begin
    case (mode)
      3'b101:  adv = phase[0];
      3'b111:  adv = (phase == 2'd1);
      default: adv = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan   <= '0;
      active <= 1'b0;
    end else if (tick) begin
      if (start) begin
        scan   <= '0;
        active <= 1'b1;
      end else if (active && adv) begin
        scan <= scan + SW'(1);
        if (scan == LAST) active <= 1'b0;
      end
    end
  end

  AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(scan) && $stable(active)));  // R6

  AST_STRETCH4_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start && mode == 3'b111 && phase != 2'd1) |=> $stable(scan));  // R7

endmodule

// File: rtl/sprite_gfx_buf.sv
module sprite_gfx_buf #(
  parameter int PIXELS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gfx_wr,
  input  logic [PIXELS-1:0] gfx_data,
  input  logic              partner_wr,
  input  logic              delay_sel,
  output logic [PIXELS-1:0] gfx_sel
);

  logic [PIXELS-1:0] cur_q;
  logic [PIXELS-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      held_q <= '0;
    end else begin
      if (gfx_wr)     cur_q  <= gfx_data;
      if (partner_wr) held_q <= cur_q;
    end
  end

  assign gfx_sel = delay_sel ? held_q : cur_q;

  AST_HELD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    partner_wr |=> (held_q == $past(cur_q)));  // R9
  AST_CUR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !gfx_wr |=> $stable(cur_q));  // R9

endmodule

// File: rtl/sprite_unit.sv
module sprite_unit
  import sprite_pkg::*;
#(
  parameter int PIXELS   = 8,
  parameter int PERIOD   = 40,
  parameter int CLOSE_AT = 3,
  parameter int MED_AT   = 7,
  parameter int FAR_AT   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              motion_en,
  input  logic              stuff_pulse,
  input  logic              pos_reset,
  input  logic              gfx_wr,
  input  logic [PIXELS-1:0] gfx_data,
  input  logic              partner_wr,
  input  logic [2:0]        mode,
  input  logic              reflect,
  input  logic              delay_sel,
  output logic              pix
);

  localparam int SW = $clog2(PIXELS);

  logic              tick;
  logic              tick_scan;
  logic [1:0]        phase;
  logic              start;
  logic [SW-1:0]     scan;
  logic              active;
  logic [PIXELS-1:0] gfx_sel;
  logic [SW-1:0]     bit_idx;

  assign tick      = motion_en | stuff_pulse;
  assign tick_scan = tick & ~pos_reset;

  sprite_pos_counter #(
    .PERIOD(PERIOD), .CLOSE_AT(CLOSE_AT), .MED_AT(MED_AT), .FAR_AT(FAR_AT)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pos_reset(pos_reset),
    .mode(mode), .phase(phase), .start(start)
  );

  sprite_scan #(.PIXELS(PIXELS)) u_scan (
    .clk(clk), .rst_n(rst_n), .tick(tick_scan), .start(start),
    .mode(mode), .phase(phase), .scan(scan), .active(active)
  );

  sprite_gfx_buf #(.PIXELS(PIXELS)) u_gfx (
    .clk(clk), .rst_n(rst_n), .gfx_wr(gfx_wr), .gfx_data(gfx_data),
    .partner_wr(partner_wr), .delay_sel(delay_sel), .gfx_sel(gfx_sel)
  );

  assign bit_idx = reflect ? scan : ~scan;
  assign pix     = active & gfx_sel[bit_idx];

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !pix);  // R10

endmodule

// File: tb/test_sprite_unit.sv
module test_sprite_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       motion_en = 1'b0, stuff_pulse = 1'b0, pos_reset = 1'b0;
  logic       gfx_wr = 1'b0, partner_wr = 1'b0;
  logic [7:0] gfx_data = '0;
  logic [2:0] mode = '0;
  logic       reflect = 1'b0, delay_sel = 1'b0;
  logic       pix;

  int checks = 0, fails = 0, n = 0;
  bit done = 0;
  string tag = "R10";
  logic [7:0] m_cur = '0, m_held = '0;
  logic a_me = 0, a_st = 0, a_pr = 0, a_gw = 0, a_pw = 0;
  logic [7:0] a_gd = '0;
  logic [2:0] a_md = '0;
  logic exp_q[$];

  always #5 clk = ~clk;

  sprite_unit i_sprite_unit (
    .clk(clk), .rst_n(rst_n), .motion_en(motion_en), .stuff_pulse(stuff_pulse),
    .pos_reset(pos_reset), .gfx_wr(gfx_wr), .gfx_data(gfx_data),
    .partner_wr(partner_wr), .mode(mode), .reflect(reflect),
    .delay_sel(delay_sel), .pix(pix)
  );

  // Expected pixel after t completed ticks, from R1, R2, R7, R8.
  function automatic logic exp_pix(int t, logic [2:0] md, logic rf, logic [7:0] g);
    int dec [4] = '{3, 7, 15, 39};
    int s = (md == 3'b101) ? 2 : (md == 3'b111) ? 4 : 1;
    for (int m = 0; m <= t / 160 + 1; m++) begin
      for (int c = 0; c < 4; c++) begin
        logic en;
        int l, p;
        case (c)
          0: en = (md == 3'b001) || (md == 3'b011);
          1: en = (md == 3'b010) || (md == 3'b011) || (md == 3'b110);
          2: en = (md == 3'b100) || (md == 3'b110);
          default: en = 1'b1;
        endcase
        l = 4 * dec[c] + 6 + 160 * m;
        if (en && t >= l && t < l + 8 * s) begin
          p = (t - l) / s;
          return rf ? g[p] : g[7 - p];
        end
      end
    end
    return 1'b0;
  endfunction

  // Driver: update the model with the inputs applied last cycle, apply new ones, push expectation.
  task automatic step(input logic me, st, pr, gw, input logic [7:0] gd,
                      input logic pw, rf, dl, input logic [2:0] md);
    @(posedge clk);
    #2;
    if (a_pr) n = 0;
    else if (a_me | a_st) n++;
    if (a_pw) m_held = m_cur;
    if (a_gw) m_cur = a_gd;
    motion_en = me; stuff_pulse = st; pos_reset = pr;
    gfx_wr = gw; gfx_data = gd; partner_wr = pw;
    reflect = rf; delay_sel = dl; mode = md;
    a_me = me; a_st = st; a_pr = pr; a_gw = gw; a_gd = gd; a_pw = pw; a_md = md;
    exp_q.push_back(exp_pix(n, md, rf, dl ? m_held : m_cur));
  endtask

  // Monitor: compare each expectation half a cycle later.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic e;
      e = exp_q.pop_front();
      checks++;
      if (pix !== e) begin
        fails++;
        $display("FAIL %s: tick %0d pix=%b expected %b", tag, n, pix, e);
      end
    end
  end

  task automatic restart_pos();
    step(0, 0, 1, 0, 8'h00, 0, 0, 0, a_md);
  endtask

  initial begin
    // R10: output low while held in reset
    repeat (3) @(negedge clk);
    checks++;
    if (pix !== 1'b0) begin
      fails++;
      $display("FAIL R10: pix=%b in reset expected 0", pix);
    end
    @(posedge clk); #2; rst_n = 1'b1;

    // R9: graphics load, held copy, simultaneous strobes
    tag = "R9";
    step(0, 0, 0, 1, 8'hC3, 0, 0, 0, 3'b000);
    step(0, 0, 0, 1, 8'h5A, 1, 0, 0, 3'b000);

    // R1/R3: main copy only, a mid-line position reset at an odd phase
    tag = "R3";
    for (int i = 0; i < 101; i++) step(1, 0, 0, 0, 8'h00, 0, 0, 0, 3'b000);
    restart_pos();
    tag = "R1";
    for (int i = 0; i < 380; i++) step(1, 0, 0, 0, 8'h00, 0, 0, 0, 3'b000);

    // R8/R9: reflect and select toggled mid-draw, writes interleaved
    tag = "R8";
    restart_pos();
    for (int i = 0; i < 380; i++) begin
      logic rf, dl, gw, pw;
      rf = ((i / 3) % 2) == 1;
      dl = ((i / 5) % 2) == 1;
      gw = (i % 37) == 4;
      pw = (i % 53) == 9;
      step(1, 0, 0, gw, 8'(i * 29 + 7), pw, rf, dl, 3'b000);
    end

    // R2/R7: every copy/stretch mode over two periods
    for (int md = 0; md < 8; md++) begin
      tag = (md == 5 || md == 7) ? "R7" : "R2";
      step(0, 0, 0, 1, 8'hB1, 0, 0, 0, a_md);
      restart_pos();
      for (int i = 0; i < 380; i++) step(1, 0, 0, 0, 8'h00, 0, 0, 0, 3'(md));
    end

    // R4/R5/R6: irregular holds with stuffed pulses in the gaps, 2x stretch
    tag = "R5";
    step(0, 0, 0, 1, 8'h96, 0, 0, 0, a_md);
    restart_pos();
    for (int i = 0; i < 700; i++) begin
      logic me, st;
      me = (i % 5) < 3 && (i % 23) != 11;
      st = !me && (i % 7) == 0;
      tag = st ? "R5" : (me ? "R6" : "R4");
      step(me, st, 0, 0, 8'h00, 0, 0, 0, 3'b101);
    end
    step(0, 0, 0, 0, 8'h00, 0, 0, 0, 3'b101);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule